// File: doc/BRIEF.md
# Snooping MOESI Line State Controller

This block holds the coherence state of every line of one small private cache on a shared snooping bus. The state table is indexed by line number and keeps one of five states per line: Modified, Owned, Exclusive, Shared or Invalid. Tag matching, the data array, memory timing and bus arbitration are handled elsewhere. The block only sees line indices and operation codes.

Local processor requests arrive on a valid/ready channel. In the cycle a request is accepted, the block reports a hit, or it drives the bus transaction the request needs. The bus is a single-cycle broadcast: the issued transaction, the shared-line answer from other caches and the state update all fall in the same cycle. Remote transactions arrive on the snoop inputs. For each one the block drives the shared line, supplies data in place of memory when it holds the owning copy, or flushes dirty data before it invalidates the line. Back-pressure rule: a snoop always has priority. `req_ready` is low in any cycle with `snp_valid` high. A request offered in such a cycle is not accepted and has no effect, and the requester holds it until `req_ready` is high.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read of any line is a miss that issues a bus read.
- R2: Local read (`req_op`=0) of a Modified, Owned, Exclusive or Shared line raises `req_hit` with no bus transaction. A read of an Invalid line issues bus read (`bus_op`=1) and fills to Exclusive when `bus_shared_in` is low, or to Shared when it is high.
- R3: Local write (`req_op`=1) to a Modified or Exclusive line hits with no bus transaction, and an Exclusive line becomes Modified.
- R4: Local write to a Shared line issues a memory-updating invalidating write (`bus_op`=3), and the line becomes Exclusive.
- R5: Local write to an Owned line issues an invalidate (`bus_op`=4), and a write to an Invalid line issues a read-for-ownership (`bus_op`=2). Both leave the line Modified.
- R6: A remote read (`snp_op`=1) hitting a Modified line asserts `snp_supply` and `snp_shared` and moves the line to Owned with no writeback. An Owned line keeps answering each remote read the same way and stays Owned.
- R7: A remote read hitting an Exclusive line asserts `snp_shared` and moves the line to Shared. On a Shared line it asserts `snp_shared` and keeps the state. On an Invalid line it drives nothing.
- R8: A remote read-for-ownership (2), update (3) or invalidate (4) moves any valid line to Invalid. `snp_flush` is asserted in that cycle only if the line was Modified or Owned.
- R9: Evict (`req_op`=2) of a Modified or Owned line issues a writeback (`bus_op`=5) and leaves the line Invalid. Evicting an Exclusive or Shared line is a silent hit to Invalid. Evicting an Invalid line is a hit that changes nothing.
- R10: `req_ready` is low while `snp_valid` is high. A request that is not accepted issues no bus transaction and leaves the table unchanged.
- R11: A remote writeback (`snp_op`=5) and the unused request code 3 drive no output and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request offered |
| req_ready | output | 1 | Local request accepted this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 evict |
| req_line | input | IDX_W | Line index of the local request |
| req_hit | output | 1 | Accepted request completes without a bus transaction |
| bus_valid | output | 1 | Bus transaction issued this cycle |
| bus_op | output | 3 | 1 read, 2 read-for-ownership, 3 update, 4 invalidate, 5 writeback |
| bus_line | output | IDX_W | Line index of the issued transaction |
| bus_shared_in | input | 1 | Another cache holds the line (answer to our bus read) |
| snp_valid | input | 1 | Remote transaction present |
| snp_op | input | 3 | Remote transaction code, same encoding as bus_op |
| snp_line | input | IDX_W | Line index of the remote transaction |
| snp_shared | output | 1 | This cache keeps a copy after the remote read |
| snp_supply | output | 1 | This cache supplies read data instead of memory |
| snp_flush | output | 1 | This cache puts dirty data on the bus before invalidating |

## Verification
The assertions check on every cycle that no bus transaction appears while a snoop holds the channel. They also check that an unanswered read always maps to a bus read, that a writeback only comes from an evict, and that a line which just supplied data or was just invalidated answers the next local read correctly. Only the bench's scenarios can show the full state walks. These are Shared becoming Exclusive after an update, an Owned line answering repeated remote reads, a silent eviction, the fill state chosen by the shared line, and the recovery of every line to Invalid after a mid-run reset.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    REQ_RD  = 2'd0,
    REQ_WR  = 2'd1,
    REQ_EV  = 2'd2,
    REQ_NOP = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_RD   = 3'd1,
    BUS_RDX  = 3'd2,
    BUS_UPD  = 3'd3,
    BUS_INV  = 3'd4,
    BUS_WB   = 3'd5
  } bus_op_e;
endpackage

// File: rtl/moesi_state_table.sv
module moesi_state_table
  import moesi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_e         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_e         b_st,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  line_st_e         w_st
);
  line_st_e st_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        st_q[g] <= ST_I;
      else if (we && (w_idx == IDX_W'(g)))
        st_q[g] <= w_st;
    end
  end

  assign a_st = st_q[a_idx];
  assign b_st = st_q[b_idx];
endmodule

// File: rtl/moesi_local_dec.sv
module moesi_local_dec
  import moesi_pkg::*;
(
  input  req_op_e  op,
  input  line_st_e cur,
  input  logic     shared_in,
  output logic     hit,
  output bus_op_e  bus_op,
  output logic     upd,
  output line_st_e nxt
);
  always_comb begin
    hit    = 1'b0;
    bus_op = BUS_NONE;
    upd    = 1'b0;
    nxt    = cur;
    unique case (op)
      REQ_RD: begin
        if (cur == ST_I) begin
          bus_op = BUS_RD;
          upd    = 1'b1;
          nxt    = shared_in ? ST_S : ST_E;
        end else begin
          hit = 1'b1;
        end
      end
      REQ_WR: begin
        unique case (cur)
          ST_M: hit = 1'b1;
          ST_E: begin hit = 1'b1; upd = 1'b1; nxt = ST_M; end
          ST_S: begin bus_op = BUS_UPD; upd = 1'b1; nxt = ST_E; end
          ST_O: begin bus_op = BUS_INV; upd = 1'b1; nxt = ST_M; end
          default: begin bus_op = BUS_RDX; upd = 1'b1; nxt = ST_M; end
        endcase
      end
      REQ_EV: begin
        if (cur == ST_M || cur == ST_O) begin
          bus_op = BUS_WB;
        end else begin
          hit = 1'b1;
        end
        upd = (cur != ST_I);
        nxt = ST_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/moesi_snoop_dec.sv
module moesi_snoop_dec
  import moesi_pkg::*;
(
  input  bus_op_e  op,
  input  line_st_e cur,
  output logic     supply,
  output logic     shared,
  output logic     flush,
  output logic     upd,
  output line_st_e nxt
);
  always_comb begin
    supply = 1'b0;
    shared = 1'b0;
    flush  = 1'b0;
    upd    = 1'b0;
    nxt    = cur;
    case (op)
      BUS_RD: begin
        unique case (cur)
          ST_M: begin supply = 1'b1; shared = 1'b1; upd = 1'b1; nxt = ST_O; end
          ST_O: begin supply = 1'b1; shared = 1'b1; end
          ST_E: begin shared = 1'b1; upd = 1'b1; nxt = ST_S; end
          ST_S: shared = 1'b1;
          default: ;
        endcase
      end
      BUS_RDX, BUS_UPD, BUS_INV: begin
        if (cur != ST_I) begin
          flush = (cur == ST_M) || (cur == ST_O);
          upd   = 1'b1;
          nxt   = ST_I;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_line,
  output logic             req_hit,
  output logic             bus_valid,
  output logic [2:0]       bus_op,
  output logic [IDX_W-1:0] bus_line,
  input  logic             bus_shared_in,
  input  logic             snp_valid,
  input  logic [2:0]       snp_op,
  input  logic [IDX_W-1:0] snp_line,
  output logic             snp_shared,
  output logic             snp_supply,
  output logic             snp_flush
);
  line_st_e loc_st, snp_st, l_nxt, s_nxt, w_st;
  bus_op_e  l_bus;
  logic     l_hit, l_upd, s_sup, s_shr, s_flu, s_upd;
  logic     req_fire, we;
  logic [IDX_W-1:0] w_idx;

  assign req_ready = !snp_valid;
  assign req_fire  = req_valid && req_ready;

  moesi_state_table #(.LINES(LINES)) table_i (
    .clk(clk), .rst_n(rst_n),
    .a_idx(req_line), .a_st(loc_st),
    .b_idx(snp_line), .b_st(snp_st),
    .we(we), .w_idx(w_idx), .w_st(w_st)
  );

  moesi_local_dec loc_i (
    .op(req_op_e'(req_op)), .cur(loc_st), .shared_in(bus_shared_in),
    .hit(l_hit), .bus_op(l_bus), .upd(l_upd), .nxt(l_nxt)
  );

  moesi_snoop_dec snp_i (
    .op(bus_op_e'(snp_op)), .cur(snp_st),
    .supply(s_sup), .shared(s_shr), .flush(s_flu), .upd(s_upd), .nxt(s_nxt)
  );

  assign req_hit    = req_fire && l_hit;
  assign bus_valid  = req_fire && (l_bus != BUS_NONE);
  assign bus_op     = bus_valid ? 3'(l_bus) : 3'(BUS_NONE);
  assign bus_line   = req_line;
  assign snp_shared = snp_valid && s_shr;
  assign snp_supply = snp_valid && s_sup;
  assign snp_flush  = snp_valid && s_flu;

  always_comb begin
    if (snp_valid) begin
      we = s_upd; w_idx = snp_line; w_st = s_nxt;
    end else begin
      we = req_fire && l_upd; w_idx = req_line; w_st = l_nxt;
    end
  end

  // R10: a snoop cycle never carries a local bus transaction
  assert_no_bus_in_snoop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !bus_valid);

  // R2: an accepted read that does not hit always goes out as a bus read
  assert_read_miss_busrd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_op == 2'(REQ_RD) && !req_hit) |-> (bus_valid && bus_op == 3'(BUS_RD)));

  // R9: a writeback only comes from an evict
  assert_wb_from_evict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_op == 3'(BUS_WB)) |-> (req_op == 2'(REQ_EV)));

  // R6: a line that just supplied data still hits on a local read
  assert_owner_keeps_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_valid && snp_op == 3'(BUS_RD) && snp_supply) && req_fire &&
     req_op == 2'(REQ_RD) && req_line == $past(snp_line)) |-> req_hit);

  // R8: a line just invalidated by the bus misses on the next local read
  assert_invalidated_misses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_valid && (snp_op == 3'(BUS_RDX) || snp_op == 3'(BUS_UPD) ||
                         snp_op == 3'(BUS_INV))) && req_fire &&
     req_op == 2'(REQ_RD) && req_line == $past(snp_line)) |-> (bus_op == 3'(BUS_RD)));
endmodule

// File: tb/moesi_line_ctrl_tb_top.sv
module moesi_line_ctrl_tb_top;
  localparam int LINES = 16;
  localparam int IDX_W = $clog2(LINES);
  localparam int NV = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, bus_shared_in = 1'b0, snp_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [2:0] snp_op = '0;
  logic [IDX_W-1:0] req_line = '0, snp_line = '0;
  logic req_ready, req_hit, bus_valid, snp_shared, snp_supply, snp_flush;
  logic [2:0] bus_op;
  logic [IDX_W-1:0] bus_line;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  moesi_line_ctrl #(.LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_line(req_line),
    .req_hit(req_hit), .bus_valid(bus_valid), .bus_op(bus_op), .bus_line(bus_line),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_op(snp_op),
    .snp_line(snp_line), .snp_shared(snp_shared), .snp_supply(snp_supply),
    .snp_flush(snp_flush)
  );

  // {req_tag[3:0], snoop, op[2:0], line[3:0], shared_in,
  //  exp bus_valid, exp bus_op[2:0], exp hit, exp supply, exp shared, exp flush}
  localparam logic [20:0] VEC [NV] = '{
    {4'd1, 1'b0,3'd0,4'd1,1'b0, 1'b1,3'd1,1'b0,1'b0,1'b0,1'b0}, // R1 first read misses
    {4'd2, 1'b0,3'd0,4'd1,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R2 E read hit
    {4'd3, 1'b0,3'd1,4'd1,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R3 E write -> M
    {4'd3, 1'b0,3'd0,4'd1,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R3 M read hit
    {4'd6, 1'b1,3'd1,4'd1,1'b0, 1'b0,3'd0,1'b0,1'b1,1'b1,1'b0}, // R6 M -> O supply
    {4'd6, 1'b1,3'd1,4'd1,1'b0, 1'b0,3'd0,1'b0,1'b1,1'b1,1'b0}, // R6 O supplies again
    {4'd2, 1'b0,3'd0,4'd1,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R2 O read hit
    {4'd5, 1'b0,3'd1,4'd1,1'b0, 1'b1,3'd4,1'b0,1'b0,1'b0,1'b0}, // R5 O write -> INV
    {4'd8, 1'b1,3'd2,4'd1,1'b0, 1'b0,3'd0,1'b0,1'b0,1'b0,1'b1}, // R8 M flush on RDX
    {4'd2, 1'b0,3'd0,4'd1,1'b1, 1'b1,3'd1,1'b0,1'b0,1'b0,1'b0}, // R2 miss fills S
    {4'd2, 1'b0,3'd0,4'd1,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R2 S read hit
    {4'd4, 1'b0,3'd1,4'd1,1'b0, 1'b1,3'd3,1'b0,1'b0,1'b0,1'b0}, // R4 S write -> UPD
    {4'd7, 1'b1,3'd1,4'd1,1'b0, 1'b0,3'd0,1'b0,1'b0,1'b1,1'b0}, // R7 E -> S
    {4'd4, 1'b0,3'd1,4'd1,1'b0, 1'b1,3'd3,1'b0,1'b0,1'b0,1'b0}, // R4 S write again
    {4'd8, 1'b1,3'd4,4'd1,1'b0, 1'b0,3'd0,1'b0,1'b0,1'b0,1'b0}, // R8 E invalidate silent
    {4'd5, 1'b0,3'd1,4'd2,1'b0, 1'b1,3'd2,1'b0,1'b0,1'b0,1'b0}, // R5 I write -> RDX
    {4'd9, 1'b0,3'd2,4'd2,1'b0, 1'b1,3'd5,1'b0,1'b0,1'b0,1'b0}, // R9 evict M -> WB
    {4'd2, 1'b0,3'd0,4'd2,1'b0, 1'b1,3'd1,1'b0,1'b0,1'b0,1'b0}, // R2 miss fills E
    {4'd9, 1'b0,3'd2,4'd2,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R9 evict E silent
    {4'd2, 1'b0,3'd0,4'd2,1'b1, 1'b1,3'd1,1'b0,1'b0,1'b0,1'b0}, // R2 miss fills S
    {4'd7, 1'b1,3'd1,4'd2,1'b0, 1'b0,3'd0,1'b0,1'b0,1'b1,1'b0}, // R7 S stays S
    {4'd11,1'b1,3'd5,4'd2,1'b0, 1'b0,3'd0,1'b0,1'b0,1'b0,1'b0}, // R11 remote WB ignored
    {4'd11,1'b0,3'd0,4'd2,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R11 line still S
    {4'd9, 1'b0,3'd2,4'd2,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R9 evict S silent
    {4'd7, 1'b1,3'd1,4'd3,1'b0, 1'b0,3'd0,1'b0,1'b0,1'b0,1'b0}, // R7 I no response
    {4'd9, 1'b0,3'd2,4'd3,1'b0, 1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R9 evict I nothing
    {4'd5, 1'b0,3'd1,4'd3,1'b0, 1'b1,3'd2,1'b0,1'b0,1'b0,1'b0}, // R5 I write -> RDX
    {4'd8, 1'b1,3'd3,4'd3,1'b0, 1'b0,3'd0,1'b0,1'b0,1'b0,1'b1}, // R8 M flush on UPD
    {4'd2, 1'b0,3'd0,4'd3,1'b0, 1'b1,3'd1,1'b0,1'b0,1'b0,1'b0}, // R2 miss fills E
    {4'd8, 1'b1,3'd2,4'd3,1'b0, 1'b0,3'd0,1'b0,1'b0,1'b0,1'b0}, // R8 E RDX no flush
    {4'd5, 1'b0,3'd1,4'd15,1'b0,1'b1,3'd2,1'b0,1'b0,1'b0,1'b0}, // R5 last line RDX
    {4'd6, 1'b1,3'd1,4'd15,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,1'b0}, // R6 last line -> O
    {4'd11,1'b0,3'd3,4'd15,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0}, // R11 code 3 ignored
    {4'd2, 1'b0,3'd0,4'd15,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0}, // R2 O still hit
    {4'd8, 1'b1,3'd4,4'd15,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b1}, // R8 O flush on INV
    {4'd8, 1'b0,3'd0,4'd15,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0}  // R8 now Invalid
  };

  function automatic logic [7:0] outs();
    return {bus_valid, bus_op, req_hit, snp_supply, snp_shared, snp_flush};
  endfunction

  task automatic check(input int tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // drive at negedge, settle, leave the posedge to commit
  task automatic drive(input logic is_snp, input logic [2:0] op, input logic [IDX_W-1:0] ln, input logic sh);
    @(negedge clk);
    req_valid = !is_snp; snp_valid = is_snp;
    req_op = op[1:0]; req_line = ln; snp_op = op; snp_line = ln; bus_shared_in = sh;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; snp_valid = 1'b0; bus_shared_in = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: idle after reset, channel ready, no output active
    check(1, "reset idle", {req_ready, outs()}[7:0], 8'b0);
    check(10, "ready after reset", {7'b0, req_ready}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16], VEC[i][15:13], VEC[i][12:9], VEC[i][8]);
      check(int'(VEC[i][20:17]), $sformatf("vector %0d", i), outs(), VEC[i][7:0]);
      if (VEC[i][7] && bus_line !== VEC[i][12:9]) begin
        checks++; fails++;
        $display("FAIL R2 bus_line: actual %0d expected %0d", bus_line, VEC[i][12:9]);
      end
    end
    idle();

    // R10: collision, snoop read on line 5 with a write to line 4 offered
    drive(1'b1, 3'd1, 4'd5, 1'b0);
    req_valid = 1'b1; req_op = 2'd1; req_line = 4'd4; #1;
    check(10, "ready low in snoop", {7'b0, req_ready}, 8'd0);
    check(10, "no bus in snoop", {7'b0, bus_valid}, 8'd0);
    // R10: line 4 must still be Invalid, so a read misses
    drive(1'b0, 3'd0, 4'd4, 1'b0);
    check(10, "blocked write had no effect", outs(), 8'b1_001_0000);

    // R1: make line 5 Modified, then reset mid-run
    drive(1'b0, 3'd1, 4'd5, 1'b0);
    check(5, "line5 rdx", outs(), 8'b1_010_0000);
    idle();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 3'd1, 4'd5, 1'b0);
    check(1, "no owner after reset", outs(), 8'b0);
    drive(1'b0, 3'd0, 4'd5, 1'b0);
    check(1, "line5 invalid after reset", outs(), 8'b1_001_0000);
    drive(1'b0, 3'd0, 4'd4, 1'b0);
    check(1, "line4 invalid after reset", outs(), 8'b1_001_0000);
    idle();
    repeat (2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule